// File: doc/BRIEF.md
# Bandwidth-Limited Commit Sequencer

This block decides, once per clock, which instructions leave the head of a multi-threaded reorder buffer. The buffer presents, for every thread, a window of its oldest `W` entries with a small set of attribute flags and a sequence number. The sequencer walks commit slots in order. On each slot a thread selector picks a thread whose current head is ready, and the head is then retired, held or turned into a request back to the execution side. The walk ends when the commit width is used up, when no thread can be picked, or when a head needs special handling.

The decisions are combinational, so the buffer can pop `retire_cnt_o` entries per thread at the next edge. Entries that were already squashed are dropped without using bandwidth. Unexecuted serialising instructions and unexecuted loads produce a release request that carries the sequence number. Faulting heads raise a trap request. Registered side state holds the newest committed sequence number of each thread, a sticky flag for malformed heads, a histogram of commit slots used per cycle and a count of cycles that used the full width. Selection defaults to oldest-first. A parameter switches it to a rotating order.

Top module: `csq_commit_seq`

## Requirements
- R1: In one cycle at most `W` (default 4) instructions commit (`slots_used_o` ≤ W). Commit continues across threads until the width is reached or no thread has an eligible head.
- R2: Each window entry is `SEQ_W`+8 bits: the sequence number in bits [SEQ_W-1:0], then the flags valid (SEQ_W+0), ready (+1), executed (+2), squashed (+3), fault (+4), serialising (+5), load (+6) and nop/prefetch (+7). Thread `t`, position `k` sits at entry index `t*W+k`. A head is eligible only when its thread enable bit is set and the entry is valid and ready. A head that is not eligible ends that thread's commit for the cycle.
- R3: A squashed head is removed: it counts in `retire_cnt_o` but not in `slots_used_o` or `insts_o`, and commit goes on with the next entry.
- R4: An unexecuted serialising head is held, with no release and no commit, when it is not in the first slot of the cycle or when stores are pending. Otherwise it produces a release (`rel_valid_o`=1, `rel_uncached_o`=0, with its tid and sequence number). Either way, commit stops for the cycle.
- R5: An unexecuted load head that is not serialising produces an uncached release (`rel_uncached_o`=1) in any slot, and commit stops for the cycle.
- R6: An executed faulting head raises `trap_valid_o` with its tid and sequence number, but only in the first slot with no stores pending. Otherwise it waits. Either way, commit stops.
- R7: Nop/prefetch heads commit and use a slot, but are not counted in `insts_o`.
- R8: After each clock edge out of reset, histogram bin `slots_used_o` (bin b at `hist_o[b*CNT_W +: CNT_W]`) increments by one. `full_cycles_o` increments when `slots_used_o` equals W.
- R9: An unexecuted head that is none of serialising or load sets `err_o` at the next edge, and `err_o` stays set until reset.
- R10: At the edge after a cycle in which a thread commits, that thread's `done_seq_o` field (thread t at `[t*SEQ_W +: SEQ_W]`) becomes the sequence number of its newest committed instruction. Otherwise the field holds.
- R11: With the default oldest-first policy, each slot picks the eligible head with the smallest sequence number (unsigned compare). On a tie the lower thread index wins.
- R12: Reset clears `done_seq_o`, `err_o`, every histogram bin and `full_cycles_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| thr_en_i | input | T | per-thread commit enable |
| stores_pend_i | input | 1 | stores still waiting for writeback |
| head_win_i | input | T*W*(SEQ_W+8) | head windows of all threads |
| retire_cnt_o | output | T*CUR_W | entries to pop per thread this cycle |
| slots_used_o | output | CUR_W | commit slots used this cycle |
| insts_o | output | CUR_W | committed instructions excluding nops |
| rel_valid_o | output | 1 | release request to execution side |
| rel_tid_o | output | TID_W | thread of the release |
| rel_seq_o | output | SEQ_W | sequence number of the release |
| rel_uncached_o | output | 1 | release is an uncached load |
| trap_valid_o | output | 1 | trap request |
| trap_tid_o | output | TID_W | thread of the trap |
| trap_seq_o | output | SEQ_W | sequence number of the faulting head |
| done_seq_o | output | T*SEQ_W | newest committed sequence number per thread |
| err_o | output | 1 | sticky malformed-head flag |
| hist_o | output | (W+1)*CNT_W | per-cycle slot-usage histogram |
| full_cycles_o | output | CNT_W | cycles that used the full width |

## Verification
The bench goes after slot-position effects. These include a serialising or faulting head in slot 0 versus a later slot, and the same head with stores pending. A design that ignored the slot index would release or trap behind younger commits, and one that ignored stores would issue the request too early. Squashed heads mixed into a full window check that dropped entries neither use bandwidth nor stop the walk. A design that counted them would report too few commits or stop early. Interleaved threads with alternating sequence numbers check oldest-first order and per-thread done numbers. Nop-heavy windows check that the instruction count and the slot count stay separate, and every cycle compares the full histogram.

// File: rtl/csq_pkg.sv
package csq_pkg;

    localparam int FLAG_W = 8;

    // Declared MSB first: valid ends up at bit 0 of the flag byte.
    typedef struct packed {
        logic nop;
        logic load;
        logic serial;
        logic fault;
        logic squashed;
        logic executed;
        logic ready;
        logic valid;
    } head_flags_t;

    typedef enum logic [0:0] {
        SEL_OLDEST = 1'b0,
        SEL_ROTATE = 1'b1
    } sel_policy_e;

    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_COMMIT   = 3'd1,
        ACT_DROP     = 3'd2,
        ACT_HOLD     = 3'd3,
        ACT_RELEASE  = 3'd4,
        ACT_UNCACHED = 3'd5,
        ACT_TRAP     = 3'd6,
        ACT_BAD      = 3'd7
    } slot_act_e;

    // Decide what one selected head does in the current slot.
    function automatic slot_act_e classify(head_flags_t f, logic first_slot,
                                           logic st_pend);
        slot_act_e a;
        if (f.squashed)
            a = ACT_DROP;
        else if (!f.executed) begin
            if (f.serial)
                a = (first_slot && !st_pend) ? ACT_RELEASE : ACT_HOLD;
            else if (f.load)
                a = ACT_UNCACHED;
            else
                a = ACT_BAD;
        end else if (f.fault)
            a = (first_slot && !st_pend) ? ACT_TRAP : ACT_HOLD;
        else
            a = ACT_COMMIT;
        return a;
    endfunction

endpackage

// File: rtl/csq_select.sv
module csq_select
    import csq_pkg::*;
#(
    parameter int          T      = 2,
    parameter int          SEQ_W  = 8,
    parameter sel_policy_e POLICY = SEL_OLDEST,
    localparam int         TID_W  = (T > 1) ? $clog2(T) : 1
) (
    input  logic [T-1:0]       elig_i,
    input  logic [T*SEQ_W-1:0] seq_i,
    input  logic [TID_W-1:0]   ptr_i,
    output logic               sel_v_o,
    output logic [TID_W-1:0]   sel_tid_o
);

    generate
        if (POLICY == SEL_OLDEST) begin : g_oldest
            logic [SEQ_W-1:0] best;
            logic             unused_ptr;
            assign unused_ptr = ^ptr_i;

            always_comb begin
                sel_v_o   = 1'b0;
                sel_tid_o = '0;
                best      = '0;
                for (int t = 0; t < T; t++) begin
                    if (elig_i[t] &&
                        (!sel_v_o || seq_i[t*SEQ_W +: SEQ_W] < best)) begin
                        sel_v_o   = 1'b1;
                        sel_tid_o = TID_W'(t);
                        best      = seq_i[t*SEQ_W +: SEQ_W];
                    end
                end
            end
        end else begin : g_rotate
            logic unused_seq;
            assign unused_seq = ^seq_i;

            always_comb begin
                sel_v_o   = 1'b0;
                sel_tid_o = '0;
                for (int k = 0; k < T; k++) begin
                    int idx;
                    idx = (int'(ptr_i) + k) % T;
                    if (!sel_v_o && elig_i[idx]) begin
                        sel_v_o   = 1'b1;
                        sel_tid_o = TID_W'(idx);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/csq_slot.sv
module csq_slot
    import csq_pkg::*;
#(
    parameter int          T      = 2,
    parameter int          W      = 4,
    parameter int          SEQ_W  = 8,
    parameter sel_policy_e POLICY = SEL_OLDEST,
    localparam int         EW     = SEQ_W + FLAG_W,
    localparam int         CUR_W  = $clog2(W + 1),
    localparam int         TID_W  = (T > 1) ? $clog2(T) : 1
) (
    input  logic [T*W*EW-1:0]  win_i,
    input  logic [T-1:0]       thr_en_i,
    input  logic               stores_pend_i,
    input  logic [T*CUR_W-1:0] cur_i,
    input  logic [CUR_W-1:0]   used_i,
    input  logic [CUR_W-1:0]   insts_i,
    input  logic               stop_i,
    input  logic [TID_W-1:0]   ptr_i,
    output logic [T*CUR_W-1:0] cur_o,
    output logic [CUR_W-1:0]   used_o,
    output logic [CUR_W-1:0]   insts_o,
    output logic               stop_o,
    output logic [TID_W-1:0]   ptr_o,
    output slot_act_e          act_o,
    output logic [TID_W-1:0]   tid_o,
    output logic [SEQ_W-1:0]   seq_o
);

    localparam logic [CUR_W-1:0] W_C = CUR_W'(W);

    head_flags_t      hd_flag [T];
    logic [T*SEQ_W-1:0] hd_seq;
    logic [CUR_W-1:0] cur_a   [T];
    logic [T-1:0]     elig;
    logic             sel_v;
    logic [TID_W-1:0] sel_tid;

    // Present the entry under each thread's cursor.
    always_comb begin
        for (int t = 0; t < T; t++) begin
            cur_a[t]                  = cur_i[t*CUR_W +: CUR_W];
            hd_flag[t]                = '0;
            hd_seq[t*SEQ_W +: SEQ_W]  = '0;
            for (int k = 0; k < W; k++) begin
                if (cur_a[t] == CUR_W'(k)) begin
                    hd_flag[t] = head_flags_t'(win_i[(t*W+k)*EW + SEQ_W +: FLAG_W]);
                    hd_seq[t*SEQ_W +: SEQ_W] = win_i[(t*W+k)*EW +: SEQ_W];
                end
            end
            elig[t] = thr_en_i[t] && (cur_a[t] < W_C) &&
                      hd_flag[t].valid && hd_flag[t].ready;
        end
    end

    csq_select #(
        .T(T), .SEQ_W(SEQ_W), .POLICY(POLICY)
    ) u_sel (
        .elig_i    (elig),
        .seq_i     (hd_seq),
        .ptr_i     (ptr_i),
        .sel_v_o   (sel_v),
        .sel_tid_o (sel_tid)
    );

    always_comb begin
        cur_o   = cur_i;
        used_o  = used_i;
        insts_o = insts_i;
        stop_o  = stop_i;
        ptr_o   = ptr_i;
        act_o   = ACT_NONE;
        tid_o   = sel_tid;
        seq_o   = hd_seq[sel_tid*SEQ_W +: SEQ_W];
        if (!stop_i) begin
            if (used_i >= W_C || !sel_v) begin
                stop_o = 1'b1;
            end else begin
                ptr_o = (sel_tid == TID_W'(T - 1)) ? '0 : sel_tid + 1'b1;
                act_o = classify(hd_flag[sel_tid], used_i == '0, stores_pend_i);
                case (act_o)
                    ACT_COMMIT: begin
                        cur_o[sel_tid*CUR_W +: CUR_W] = cur_a[sel_tid] + 1'b1;
                        used_o = used_i + 1'b1;
                        if (!hd_flag[sel_tid].nop)
                            insts_o = insts_i + 1'b1;
                    end
                    ACT_DROP: begin
                        cur_o[sel_tid*CUR_W +: CUR_W] = cur_a[sel_tid] + 1'b1;
                    end
                    default: stop_o = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/csq_stats.sv
module csq_stats #(
    parameter int  W     = 4,
    parameter int  CNT_W = 16,
    localparam int CUR_W = $clog2(W + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CUR_W-1:0]       used_i,
    output logic [(W+1)*CNT_W-1:0] hist_o,
    output logic [CNT_W-1:0]       full_o
);

    generate
        for (genvar b = 0; b <= W; b++) begin : g_bin
            logic [CNT_W-1:0] bin_q;
            always_ff @(posedge clk) begin
                if (rst)
                    bin_q <= '0;
                else if (used_i == CUR_W'(b))
                    bin_q <= bin_q + 1'b1;
            end
            assign hist_o[b*CNT_W +: CNT_W] = bin_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            full_o <= '0;
        else if (used_i == CUR_W'(W))
            full_o <= full_o + 1'b1;
    end

endmodule

// File: rtl/csq_commit_seq.sv
module csq_commit_seq
    import csq_pkg::*;
#(
    parameter int          T      = 2,
    parameter int          W      = 4,
    parameter int          SEQ_W  = 8,
    parameter int          CNT_W  = 16,
    parameter sel_policy_e POLICY = SEL_OLDEST,
    localparam int         EW     = SEQ_W + FLAG_W,
    localparam int         CUR_W  = $clog2(W + 1),
    localparam int         TID_W  = (T > 1) ? $clog2(T) : 1,
    localparam int         NST    = T * W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [T-1:0]           thr_en_i,
    input  logic                   stores_pend_i,
    input  logic [T*W*EW-1:0]      head_win_i,
    output logic [T*CUR_W-1:0]     retire_cnt_o,
    output logic [CUR_W-1:0]       slots_used_o,
    output logic [CUR_W-1:0]       insts_o,
    output logic                   rel_valid_o,
    output logic [TID_W-1:0]       rel_tid_o,
    output logic [SEQ_W-1:0]       rel_seq_o,
    output logic                   rel_uncached_o,
    output logic                   trap_valid_o,
    output logic [TID_W-1:0]       trap_tid_o,
    output logic [SEQ_W-1:0]       trap_seq_o,
    output logic [T*SEQ_W-1:0]     done_seq_o,
    output logic                   err_o,
    output logic [(W+1)*CNT_W-1:0] hist_o,
    output logic [CNT_W-1:0]       full_cycles_o
);

    // Slot chain: every stage may pop one entry, so NST stages always suffice.
    logic [T*CUR_W-1:0] cur_c  [NST+1];
    logic [CUR_W-1:0]   used_c [NST+1];
    logic [CUR_W-1:0]   ins_c  [NST+1];
    logic               stop_c [NST+1];
    logic [TID_W-1:0]   ptr_c  [NST+1];
    slot_act_e          act_s  [NST];
    logic [TID_W-1:0]   tid_s  [NST];
    logic [SEQ_W-1:0]   seq_s  [NST];
    logic [TID_W-1:0]   rr_q;

    assign cur_c[0]  = '0;
    assign used_c[0] = '0;
    assign ins_c[0]  = '0;
    assign stop_c[0] = 1'b0;
    assign ptr_c[0]  = rr_q;

    generate
        for (genvar i = 0; i < NST; i++) begin : g_slot
            csq_slot #(
                .T(T), .W(W), .SEQ_W(SEQ_W), .POLICY(POLICY)
            ) u_slot (
                .win_i         (head_win_i),
                .thr_en_i      (thr_en_i),
                .stores_pend_i (stores_pend_i),
                .cur_i         (cur_c[i]),
                .used_i        (used_c[i]),
                .insts_i       (ins_c[i]),
                .stop_i        (stop_c[i]),
                .ptr_i         (ptr_c[i]),
                .cur_o         (cur_c[i+1]),
                .used_o        (used_c[i+1]),
                .insts_o       (ins_c[i+1]),
                .stop_o        (stop_c[i+1]),
                .ptr_o         (ptr_c[i+1]),
                .act_o         (act_s[i]),
                .tid_o         (tid_s[i]),
                .seq_o         (seq_s[i])
            );
        end
    endgenerate

    assign retire_cnt_o = cur_c[NST];
    assign slots_used_o = used_c[NST];
    assign insts_o      = ins_c[NST];

    logic             bad_now;
    logic [T-1:0]     com_v;
    logic [SEQ_W-1:0] com_seq [T];

    // At most one stage ends the walk with a request; later commits of a
    // thread are always younger, so the last one seen wins.
    always_comb begin
        rel_valid_o    = 1'b0;
        rel_tid_o      = '0;
        rel_seq_o      = '0;
        rel_uncached_o = 1'b0;
        trap_valid_o   = 1'b0;
        trap_tid_o     = '0;
        trap_seq_o     = '0;
        bad_now        = 1'b0;
        com_v          = '0;
        for (int t = 0; t < T; t++) com_seq[t] = '0;
        for (int i = 0; i < NST; i++) begin
            case (act_s[i])
                ACT_RELEASE, ACT_UNCACHED: begin
                    rel_valid_o    = 1'b1;
                    rel_tid_o      = tid_s[i];
                    rel_seq_o      = seq_s[i];
                    rel_uncached_o = (act_s[i] == ACT_UNCACHED);
                end
                ACT_TRAP: begin
                    trap_valid_o = 1'b1;
                    trap_tid_o   = tid_s[i];
                    trap_seq_o   = seq_s[i];
                end
                ACT_BAD: bad_now = 1'b1;
                ACT_COMMIT: begin
                    for (int t = 0; t < T; t++) begin
                        if (tid_s[i] == TID_W'(t)) begin
                            com_v[t]   = 1'b1;
                            com_seq[t] = seq_s[i];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q       <= '0;
            err_o      <= 1'b0;
            done_seq_o <= '0;
        end else begin
            rr_q <= ptr_c[NST];
            if (bad_now)
                err_o <= 1'b1;
            for (int t = 0; t < T; t++)
                if (com_v[t])
                    done_seq_o[t*SEQ_W +: SEQ_W] <= com_seq[t];
        end
    end

    csq_stats #(
        .W(W), .CNT_W(CNT_W)
    ) u_stats (
        .clk    (clk),
        .rst    (rst),
        .used_i (slots_used_o),
        .hist_o (hist_o),
        .full_o (full_cycles_o)
    );

endmodule

// File: rtl/csq_checker.sv
module csq_checker #(
    parameter int  T     = 2,
    parameter int  W     = 4,
    parameter int  SEQ_W = 8,
    parameter int  CNT_W = 16,
    localparam int CUR_W = $clog2(W + 1),
    localparam int TID_W = (T > 1) ? $clog2(T) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   stores_pend_i,
    input logic [T*CUR_W-1:0]     retire_cnt_o,
    input logic [CUR_W-1:0]       slots_used_o,
    input logic [CUR_W-1:0]       insts_o,
    input logic                   rel_valid_o,
    input logic                   rel_uncached_o,
    input logic                   trap_valid_o,
    input logic [T*SEQ_W-1:0]     done_seq_o,
    input logic                   err_o,
    input logic [CNT_W-1:0]       full_cycles_o
);

    localparam logic [CUR_W-1:0] W_C = CUR_W'(W);

    logic [CUR_W+TID_W:0] ret_sum;
    always_comb begin
        ret_sum = '0;
        for (int t = 0; t < T; t++)
            ret_sum = ret_sum + (CUR_W+TID_W+1)'(retire_cnt_o[t*CUR_W +: CUR_W]);
    end

    p_width_bound_r1: assert property (@(posedge clk) disable iff (rst)
        slots_used_o <= W_C);

    p_pops_cover_commits_r3: assert property (@(posedge clk) disable iff (rst)
        ret_sum >= (CUR_W+TID_W+1)'(slots_used_o));

    p_single_request_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rel_valid_o, trap_valid_o}));

    p_serial_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (rel_valid_o && !rel_uncached_o) |-> (!stores_pend_i && slots_used_o == '0));

    p_trap_gate_r6: assert property (@(posedge clk) disable iff (rst)
        trap_valid_o |-> (!stores_pend_i && slots_used_o == '0));

    p_nop_excluded_r7: assert property (@(posedge clk) disable iff (rst)
        insts_o <= slots_used_o);

    p_full_step_r8: assert property (@(posedge clk) disable iff (rst)
        (slots_used_o == W_C) |=> (full_cycles_o == $past(full_cycles_o) + 1'b1));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (slots_used_o == '0) |=> $stable(done_seq_o));

endmodule

bind csq_commit_seq csq_checker #(
    .T(T), .W(W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .stores_pend_i (stores_pend_i),
    .retire_cnt_o  (retire_cnt_o),
    .slots_used_o  (slots_used_o),
    .insts_o       (insts_o),
    .rel_valid_o   (rel_valid_o),
    .rel_uncached_o(rel_uncached_o),
    .trap_valid_o  (trap_valid_o),
    .done_seq_o    (done_seq_o),
    .err_o         (err_o),
    .full_cycles_o (full_cycles_o)
);

// File: tb/csq_commit_seq_bench.sv
`timescale 1ns/1ps
module csq_commit_seq_bench;

    localparam int T = 2, W = 4, SEQ_W = 8, CNT_W = 16;
    localparam int EW = SEQ_W + 8, CUR_W = 3, TID_W = 1;
    localparam logic [7:0] F_V = 8'h01, F_R = 8'h02, F_X = 8'h04, F_SQ = 8'h08,
                           F_FT = 8'h10, F_SR = 8'h20, F_LD = 8'h40, F_NP = 8'h80;
    localparam logic [7:0] OK = F_V | F_R | F_X;

    logic clk = 1'b0, rst = 1'b1;
    logic [T-1:0] thr_en = '0;
    logic stp = 1'b0;
    logic [T*W*EW-1:0] win;
    logic [T*CUR_W-1:0] retire_cnt;
    logic [CUR_W-1:0] used, insts;
    logic rel_v, rel_u, trap_v, err;
    logic [TID_W-1:0] rel_t, trap_t;
    logic [SEQ_W-1:0] rel_s, trap_s;
    logic [T*SEQ_W-1:0] done_seq;
    logic [(W+1)*CNT_W-1:0] hist;
    logic [CNT_W-1:0] full_cnt;

    always #2 clk = ~clk;

    csq_commit_seq #(.T(T), .W(W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_csq_commit_seq (
        .clk(clk), .rst(rst), .thr_en_i(thr_en), .stores_pend_i(stp),
        .head_win_i(win), .retire_cnt_o(retire_cnt), .slots_used_o(used),
        .insts_o(insts), .rel_valid_o(rel_v), .rel_tid_o(rel_t),
        .rel_seq_o(rel_s), .rel_uncached_o(rel_u), .trap_valid_o(trap_v),
        .trap_tid_o(trap_t), .trap_seq_o(trap_s), .done_seq_o(done_seq),
        .err_o(err), .hist_o(hist), .full_cycles_o(full_cnt));

    logic [7:0] fl [T][W];
    logic [7:0] sq [T][W];
    int n_chk = 0, n_bad = 0;
    string tag = "";

    // expected values
    int e_cur [T];
    int e_used, e_ins;
    logic e_rv, e_ru, e_tv, e_bad;
    int e_rt, e_tt;
    logic [7:0] e_rs, e_ts;
    logic [T-1:0] e_cv;
    logic [7:0] e_cs [T];
    logic [7:0] m_done [T];
    logic m_err;
    int m_hist [W+1];
    int m_full;

    task automatic chk(string req, string what, logic [127:0] got, logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: got %0h expected %0h", req, tag, what, got, exp);
        end
    endtask

    task automatic clear_win();
        for (int t = 0; t < T; t++)
            for (int k = 0; k < W; k++) begin
                fl[t][k] = 8'h00;
                sq[t][k] = 8'h00;
            end
    endtask

    task automatic put(int t, int k, logic [7:0] f, logic [7:0] s);
        fl[t][k] = f;
        sq[t][k] = s;
    endtask

    // Requirement-level model of one cycle.
    task automatic model();
        logic stop;
        for (int t = 0; t < T; t++) begin e_cur[t] = 0; e_cv[t] = 0; e_cs[t] = 0; end
        e_used = 0; e_ins = 0; e_rv = 0; e_ru = 0; e_tv = 0; e_bad = 0;
        e_rt = 0; e_tt = 0; e_rs = 0; e_ts = 0; stop = 0;
        for (int it = 0; it < T*W; it++) begin
            int sel;
            logic [7:0] best, f, s;
            logic first;
            if (stop || e_used >= W) break;
            sel = -1; best = 0;
            for (int t = 0; t < T; t++)
                if (thr_en[t] && e_cur[t] < W && fl[t][e_cur[t]][0] && fl[t][e_cur[t]][1]
                    && (sel < 0 || sq[t][e_cur[t]] < best)) begin
                    sel = t; best = sq[t][e_cur[t]];
                end
            if (sel < 0) break;
            f = fl[sel][e_cur[sel]]; s = sq[sel][e_cur[sel]];
            first = (e_used == 0);
            if (f & F_SQ) begin e_cur[sel]++; continue; end
            stop = 1;
            if (!(f & F_X)) begin
                if (f & F_SR) begin
                    if (first && !stp) begin e_rv = 1; e_rt = sel; e_rs = s; end
                end else if (f & F_LD) begin
                    e_rv = 1; e_ru = 1; e_rt = sel; e_rs = s;
                end else e_bad = 1;
            end else if (f & F_FT) begin
                if (first && !stp) begin e_tv = 1; e_tt = sel; e_ts = s; end
            end else begin
                stop = 0;
                e_cur[sel]++; e_used++;
                if (!(f & F_NP)) e_ins++;
                e_cv[sel] = 1; e_cs[sel] = s;
            end
        end
    endtask

    function automatic logic [127:0] hist_exp();
        logic [127:0] v = '0;
        for (int b = 0; b <= W; b++) v[b*CNT_W +: CNT_W] = CNT_W'(m_hist[b]);
        return v;
    endfunction

    function automatic logic [127:0] done_exp();
        logic [127:0] v = '0;
        for (int t = 0; t < T; t++) v[t*SEQ_W +: SEQ_W] = m_done[t];
        return v;
    endfunction

    // Called just after a rising edge.
    task automatic cycle();
        for (int t = 0; t < T; t++)
            for (int k = 0; k < W; k++)
                win[(t*W+k)*EW +: EW] = {fl[t][k], sq[t][k]};
        model();
        @(negedge clk);
        chk("R1", "retire", 128'(retire_cnt), 128'({3'(e_cur[1]), 3'(e_cur[0])}));
        chk("R1", "used", 128'(used), 128'(e_used));
        chk("R7", "insts", 128'(insts), 128'(e_ins));
        chk("R4", "release", 128'({rel_v, rel_u, rel_t, rel_s}),
            128'({e_rv, e_ru, 1'(e_rt), e_rs}));
        chk("R6", "trap", 128'({trap_v, trap_t, trap_s}), 128'({e_tv, 1'(e_tt), e_ts}));
        for (int t = 0; t < T; t++) if (e_cv[t]) m_done[t] = e_cs[t];
        if (e_bad) m_err = 1;
        m_hist[e_used]++;
        if (e_used == W) m_full++;
        @(posedge clk); #1;
        chk("R10", "done_seq", 128'(done_seq), done_exp());
        chk("R9", "err", 128'(err), 128'(m_err));
        chk("R8", "hist", 128'(hist), hist_exp());
        chk("R8", "full", 128'(full_cnt), 128'(m_full));
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        win = '0;
        clear_win();
        for (int t = 0; t < T; t++) m_done[t] = 0;
        m_err = 0; m_full = 0;
        for (int b = 0; b <= W; b++) m_hist[b] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        tag = "R12 reset state";
        chk("R12", "done_seq", 128'(done_seq), 128'(0));
        chk("R12", "err", 128'(err), 128'(0));
        chk("R12", "hist", 128'(hist), 128'(0));
        chk("R12", "full", 128'(full_cnt), 128'(0));

        tag = "R2 empty windows";
        thr_en = 2'b11; cycle();

        tag = "R2 thread disabled";
        clear_win();
        for (int k = 0; k < W; k++) put(0, k, OK, 8'(10 + k));
        thr_en = 2'b10; cycle();

        tag = "R2 head not ready stops thread";
        thr_en = 2'b11;
        put(0, 1, F_V | F_X, 8'd11);
        cycle();

        tag = "R1 full width one thread";
        clear_win();
        for (int k = 0; k < W; k++) put(0, k, OK, 8'(20 + k));
        cycle();

        tag = "R1 width caps two threads";
        clear_win();
        for (int k = 0; k < W; k++) begin
            put(0, k, OK, 8'(30 + 2*k));
            put(1, k, OK, 8'(31 + 2*k));
        end
        cycle();

        tag = "R11 oldest interleave";
        clear_win();
        put(0, 0, OK, 8'd40); put(0, 1, OK, 8'd42);
        put(1, 0, OK, 8'd41); put(1, 1, OK, 8'd43);
        cycle();

        tag = "R11 tie goes to thread 0";
        clear_win();
        put(0, 0, OK, 8'd50); put(1, 0, OK, 8'd50);
        thr_en = 2'b11; cycle();

        tag = "R10 hold without commits";
        clear_win(); cycle();

        tag = "R3 squashed heads dropped";
        clear_win();
        put(0, 0, OK | F_SQ, 8'd60); put(0, 1, OK, 8'd61);
        put(0, 2, OK | F_SQ, 8'd62); put(0, 3, OK, 8'd63);
        put(1, 0, OK, 8'd70); put(1, 1, OK, 8'd71);
        cycle();

        tag = "R7 nops use slots";
        clear_win();
        put(0, 0, OK | F_NP, 8'd80); put(0, 1, OK, 8'd81); put(0, 2, OK | F_NP, 8'd82);
        cycle();

        tag = "R4 serial in slot 0";
        clear_win(); put(0, 0, F_V | F_R | F_SR, 8'd90); cycle();
        tag = "R4 serial behind a commit";
        clear_win(); put(1, 0, OK, 8'd91); put(1, 1, F_V | F_R | F_SR, 8'd92); cycle();
        tag = "R4 serial with stores pending";
        clear_win(); put(0, 0, F_V | F_R | F_SR, 8'd93); stp = 1'b1; cycle(); stp = 1'b0;

        tag = "R5 uncached load in slot 2";
        clear_win();
        put(0, 0, OK, 8'd100); put(0, 1, OK, 8'd101); put(0, 2, F_V | F_R | F_LD, 8'd102);
        put(0, 3, OK, 8'd103); stp = 1'b1; cycle(); stp = 1'b0;

        tag = "R6 fault in slot 0";
        clear_win(); put(1, 0, OK | F_FT, 8'd110); cycle();
        tag = "R6 fault behind a commit";
        clear_win(); put(0, 0, OK, 8'd111); put(0, 1, OK | F_FT, 8'd112); cycle();
        tag = "R6 fault with stores pending";
        clear_win(); put(0, 0, OK | F_FT, 8'd113); stp = 1'b1; cycle(); stp = 1'b0;

        tag = "R9 unknown unexecuted head";
        clear_win(); put(0, 0, F_V | F_R, 8'd120); cycle();
        tag = "R9 flag stays set";
        clear_win(); put(0, 0, OK, 8'd121); cycle();

        // Random mix; err is already sticky so later bad heads only re-set it.
        tag = "random mix";
        void'($urandom(32'd5150));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] base [T];
            base[0] = 8'($urandom_range(0, 200));
            base[1] = 8'(base[0] + 2*$urandom_range(0, 3) + 1);
            for (int t = 0; t < T; t++)
                for (int k = 0; k < W; k++) begin
                    logic [7:0] f = 8'h00;
                    if ($urandom_range(0, 9) != 0) f |= F_V;
                    if ($urandom_range(0, 4) != 0) f |= F_R;
                    if ($urandom_range(0, 19) < 17) f |= F_X;
                    if ($urandom_range(0, 9) == 0) f |= F_SQ;
                    if ($urandom_range(0, 11) == 0) f |= F_FT;
                    if ($urandom_range(0, 9) == 0) f |= F_SR;
                    if ($urandom_range(0, 2) == 0) f |= F_LD;
                    if ($urandom_range(0, 6) == 0) f |= F_NP;
                    put(t, k, f, 8'(base[t] + 2*k));
                end
            thr_en = 2'($urandom_range(1, 3));
            stp = ($urandom_range(0, 3) == 0);
            cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule